// File: doc/BRIEF.md
# MII Management Register Target

This block is the target side of a bit-banged PHY management link. Software toggles a clock bit (MDC), a data-out bit (MDO) and a direction bit through register writes. The block watches those bits on the system clock. On every rising MDC it shifts one bit into a 32-bit frame word and counts it. It decodes a read request after 16 bits and a write frame after 32 bits. It returns read data one bit per MDC edge on a single MDI bit, which software samples.

The block serves a bank of 32 sixteen-bit registers at one PHY address. Each register has a fixed mask of writable bits; a write changes only the bits that mask allows. A run of ones on MDO clears the bit count, which gives the usual preamble resynchronisation. A completed 32-bit frame also clears the count, so a new request can follow at once without a preamble.

Top module: `mii_mgmt_slave`

## Requirements
- R1: Frame state changes only on a clock where `mdc_i` is 1 and was 0 on the previous clock. Holding MDC high or low for any number of clocks, or changing `mdo_i` and `rd_dir_i` while MDC is steady, has no effect.
- R2: After reset the bank holds 0x3100, 0xF02C, 0x7810, 0x0000, 0x0501 and 0x4181 in registers 0 to 5, 0x0003 in register 16, 0x0001 in register 18, and zero everywhere else.
- R3: A read request is 16 bits, MSB first: bits 15:12 = 4'b0110, bits 11:7 = PHY address, bits 6:2 = register, bits 1:0 don't care. With `rd_dir_i` = 1, `mdi_o` shows bits 14 down to 0 of the register after rising MDC edges 17 to 31 of the frame.
- R4: A write frame is 32 bits, MSB first, sent with `rd_dir_i` = 0: bits 31:28 = 4'b0101, bits 27:23 = PHY address, bits 22:18 = register, bits 17:16 don't care, bits 15:0 = data. Register becomes (old AND NOT mask) OR (data AND mask).
- R5: Writable masks are 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25, 0xC01F for register 4, 0x0FFF for register 16, and 0x0000 for all others. Bits outside the mask never change.
- R6: Only PHY address 1 (parameter default) responds. A read of any other address returns all zeros. A write to any other address changes nothing.
- R7: When the 32-bit shift word becomes all ones, the bit count returns to zero. Any stray bits before a preamble of 32 ones are forgotten.
- R8: After the 32nd bit of a frame the count returns to zero, so a new request may follow with no preamble.
- R9: A 32-bit frame whose bits 31:28 are not 4'b0101 writes nothing. A 16-bit header whose bits 15:12 are not 4'b0110 loads nothing.
- R10: `mdi_o` is 0 after reset. It changes only on a rising MDC edge at bit count 16 or later with `rd_dir_i` = 1, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_i | input | 1 | Management clock bit written by software |
| mdo_i | input | 1 | Management data bit from software to the target |
| rd_dir_i | input | 1 | 1 while the target drives read data back |
| mdi_o | output | 1 | Management data bit from the target to software |

## Verification
The hardest case to reach is a frame boundary that is out of step: stray bits left in the counter, followed by a preamble that must realign the count. The bench sends a few stray bits and then 32 ones before a read, and also runs write-then-read pairs with no preamble, so the cleared count after a full frame is exercised. Long MDC high holds and MDO/direction toggling while MDC is low show that only rising edges count. A behavioural model tracks MDI on every clock.

// File: rtl/mii_mgmt_pkg.sv
// Shared constants, register defaults and write masks for the management target.
package mii_mgmt_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 32;
    localparam int ADDR_W  = $clog2(REG_CNT);
    localparam int PHY_W   = 5;
    localparam int OP_W    = 4;

    localparam logic [OP_W-1:0] OP_READ  = 4'b0110;
    localparam logic [OP_W-1:0] OP_WRITE = 4'b0101;

    // Write request handed from the frame shifter to the register bank.
    typedef struct packed {
        logic              en;
        logic [PHY_W-1:0]  phy;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Value a register takes at reset.
    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 16'h3100;
            1:       return 16'hF02C;
            2:       return 16'h7810;
            4:       return 16'h0501;
            5:       return 16'h4181;
            16:      return 16'h0003;
            18:      return 16'h0001;
            default: return '0;
        endcase
    endfunction

    // Bits of a register that a write may change.
    function automatic logic [DATA_W-1:0] reg_wmask(input int idx);
        if (idx == 4)                          return 16'hC01F;
        if (idx == 16)                         return 16'h0FFF;
        if ((idx >= 1 && idx <= 3) || idx == 5 || idx == 6) return 16'hFFFF;
        if (idx >= 18 && idx <= 25)            return 16'hFFFF;
        return '0;
    endfunction

endpackage

// File: rtl/mdc_rise_detect.sv
// Detects a 0-to-1 change of the software-driven MDC bit.
// Assumes mdc_i is already synchronous to clk (written by a register).
module mdc_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    output logic rise_o
);

    logic mdc_q;

    // Remember last MDC value.
    always_ff @(posedge clk) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc_i;
    end

    assign rise_o = mdc_i & ~mdc_q;

endmodule

// File: rtl/mii_frame_shifter.sv
// Shift word, bit counter and frame decode for the management link.
// Assumes one rise_i pulse per MDC rising edge. Read data arrives
// combinationally from the register bank for the addressed header.
module mii_frame_shifter
    import mii_mgmt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              mdo_i,
    input  logic              rd_dir_i,
    output logic [PHY_W-1:0]  rd_phy_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output wr_req_t           wr_o,
    output logic              mdi_o
);

    localparam int HALF  = WORD_W / 2;
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mdi_q;

    logic [CNT_W-1:0]  cnt_inc;
    logic              in_bit;
    logic [WORD_W-1:0] word_sh;
    logic              all_ones;
    logic              hdr_read;
    logic              at_full;

    // Next count, next shifted word and decode qualifiers.
    always_comb begin
        cnt_inc  = cnt_q + 1'b1;
        in_bit   = mdo_i & ((cnt_inc < CNT_HALF) | ~rd_dir_i);
        word_sh  = {word_q[WORD_W-2:0], in_bit};
        all_ones = &word_sh;
        at_full  = (cnt_inc == CNT_FULL);
        hdr_read = (cnt_inc == CNT_HALF) && (word_sh[HALF-1 -: OP_W] == OP_READ);
    end

    assign rd_phy_o  = word_sh[HALF-OP_W-1 -: PHY_W];
    assign rd_addr_o = word_sh[HALF-OP_W-PHY_W-1 -: ADDR_W];

    // Write request presented for the rising edge that completes a frame.
    always_comb begin
        wr_o.en   = rise_i & ~all_ones & at_full &
                    (word_sh[WORD_W-1 -: OP_W] == OP_WRITE);
        wr_o.phy  = word_sh[WORD_W-OP_W-1 -: PHY_W];
        wr_o.addr = word_sh[WORD_W-OP_W-PHY_W-1 -: ADDR_W];
        wr_o.data = word_sh[DATA_W-1:0];
    end

    // Advance count and word once per MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (rise_i) begin
            if (all_ones || at_full) cnt_q <= '0;
            else                     cnt_q <= cnt_inc;
            if (!all_ones && hdr_read)
                word_q <= {{(WORD_W-DATA_W){1'b0}}, rd_data_i};
            else
                word_q <= word_sh;
        end
    end

    // Drive read data bit in read direction from mid-frame on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mdi_q <= 1'b0;
        else if (rise_i && rd_dir_i && (cnt_inc >= CNT_HALF))
            mdi_q <= word_sh[HALF-1];
    end

    assign mdi_o = mdi_q;

    a_r1_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> ($stable(cnt_q) && $stable(word_q)));

    a_r8_count_below_full: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_FULL);

    a_r10_mdi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_i && rd_dir_i) |=> $stable(mdi_q));

    a_r7_preamble_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && all_ones) |=> (cnt_q == '0));

endmodule

// File: rtl/mii_reg_bank.sv
// Register bank answering at one PHY address. Reads are combinational.
// A write keeps the bits outside each register's fixed mask.
module mii_reg_bank
    import mii_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  rd_phy_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  wr_req_t           wr_i
);

    localparam logic [PHY_W-1:0] PHY_SEL = PHY_W'(PHY_ADDR);

    logic [REG_CNT-1:0][DATA_W-1:0] regs;
    logic wr_hit;

    assign wr_hit    = wr_i.en && (wr_i.phy == PHY_SEL);
    assign rd_data_o = (rd_phy_i == PHY_SEL) ? regs[rd_addr_i] : '0;

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        localparam logic [DATA_W-1:0] G_RST  = reg_reset(g);
        localparam logic [DATA_W-1:0] G_MASK = reg_wmask(g);

        // Load default or merge masked write data.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= G_RST;
            else if (wr_hit && (wr_i.addr == ADDR_W'(g)))
                regs[g] <= (regs[g] & ~G_MASK) | (wr_i.data & G_MASK);
        end

        a_r5_readonly_bits: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((regs[g] & ~G_MASK) == (G_RST & ~G_MASK)));
    end

    a_r6_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.phy != PHY_SEL) |=> $stable(regs));

    a_r6_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phy_i != PHY_SEL) |-> (rd_data_o == '0));

endmodule

// File: rtl/mii_mgmt_slave.sv
// Top of the management target: edge detect, frame shifter, register bank.
// Assumes software-driven MDC/MDO/direction bits synchronous to clk.
module mii_mgmt_slave
    import mii_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int WORD_W   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdo_i,
    input  logic rd_dir_i,
    output logic mdi_o
);

    logic              rise;
    logic [PHY_W-1:0]  rd_phy;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr_req;

    mdc_rise_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .rise_o (rise)
    );

    mii_frame_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .mdo_i     (mdo_i),
        .rd_dir_i  (rd_dir_i),
        .rd_phy_o  (rd_phy),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .wr_o      (wr_req),
        .mdi_o     (mdi_o)
    );

    mii_reg_bank #(.PHY_ADDR(PHY_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_phy_i  (rd_phy),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_i      (wr_req)
    );

    a_r10_mdi_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (mdi_o == 1'b0));

endmodule

// File: tb/mii_mgmt_slave_tb_top.sv
// Bench: behavioural reference model stepped per MDC edge, compared each clock.
module mii_mgmt_slave_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdo = 1'b0;
    logic dir = 1'b0;
    logic mdi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mii_mgmt_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_i    (mdc),
        .mdo_i    (mdo),
        .rd_dir_i (dir),
        .mdi_o    (mdi)
    );

    // Reference model state.
    int       m_cnt;
    bit [31:0] m_word;
    bit [15:0] m_regs [32];
    bit        m_mdi;

    function automatic bit [15:0] exp_mask(input int i);
        if (i == 4)  return 16'hC01F;
        if (i == 16) return 16'h0FFF;
        if (i inside {1, 2, 3, 5, 6}) return 16'hFFFF;
        if (i >= 18 && i <= 25) return 16'hFFFF;
        return 16'h0000;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_word = '0; m_mdi = 0;
        foreach (m_regs[i]) m_regs[i] = 16'h0000;
        m_regs[0] = 16'h3100; m_regs[1] = 16'hF02C; m_regs[2] = 16'h7810;
        m_regs[4] = 16'h0501; m_regs[5] = 16'h4181;
        m_regs[16] = 16'h0003; m_regs[18] = 16'h0001;
    endtask

    task automatic model_step(input bit b, input bit d);
        int r;
        m_cnt = m_cnt + 1;
        m_word = {m_word[30:0], b && (m_cnt < 16 || !d)};
        if (m_cnt >= 16 && d) m_mdi = m_word[15];
        if (m_word == 32'hFFFF_FFFF) begin
            m_cnt = 0;
        end else if (m_cnt == 16) begin
            if (m_word[15:12] == 4'b0110)
                m_word = (m_word[11:7] == 5'd1) ? {16'h0, m_regs[m_word[6:2]]} : 32'h0;
        end else if (m_cnt == 32) begin
            if (m_word[31:28] == 4'b0101 && m_word[27:23] == 5'd1) begin
                r = int'(m_word[22:18]);
                m_regs[r] = (m_regs[r] & ~exp_mask(r)) | (m_word[15:0] & exp_mask(r));
            end
            m_cnt = 0;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R3/R10: per-clock comparison of MDI against the model.
    task automatic cmp();
        check("R10 mdi vs model", int'(mdi), int'(m_mdi));
    endtask

    // One MDC period: low for one clock, high for `hold` clocks.
    task automatic edge_bit(input bit b, input bit d, input int hold = 1);
        @(negedge clk); mdc = 0; mdo = b; dir = d;
        @(negedge clk); cmp();
        mdc = 1; model_step(b, d);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk); cmp();
            mdo = ~mdo;   // R1: toggling MDO while MDC is high has no effect
        end
    endtask

    task automatic send_bits(input bit [31:0] v, input int n, input bit d, input int hold = 1);
        for (int i = n - 1; i >= 0; i--) edge_bit(v[i], d, hold);
    endtask

    task automatic preamble();
        send_bits(32'hFFFF_FFFF, 32, 0);
    endtask

    task automatic do_read(input int phy, input int rg, output bit [14:0] got);
        send_bits({16'h0, 4'b0110, 5'(phy), 5'(rg), 2'b00}, 16, 1);
        for (int k = 17; k <= 32; k++) begin
            edge_bit(0, 1);
            if (k <= 31) got[31 - k] = mdi;
        end
    endtask

    task automatic do_write(input bit [3:0] op, input int phy, input int rg,
                            input bit [15:0] data, input int hold = 1);
        send_bits({op, 5'(phy), 5'(rg), 2'b10, data}, 32, 0, hold);
    endtask

    task automatic rd_check(input string tag, input int phy, input int rg, input bit [15:0] exp);
        bit [14:0] got;
        do_read(phy, rg, got);
        check(tag, int'(got), int'(exp[14:0]));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit mdi_before;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 mdi after reset", int'(mdi), 0);

        // R2 reset values through reads, no preamble needed.
        rd_check("R2 reg0", 1, 0, 16'h3100);
        rd_check("R2 reg1", 1, 1, 16'hF02C);
        rd_check("R2 reg2", 1, 2, 16'h7810);
        rd_check("R2 reg3", 1, 3, 16'h0000);
        rd_check("R2 reg4", 1, 4, 16'h0501);
        rd_check("R3 reg5", 1, 5, 16'h4181);
        rd_check("R2 reg16", 1, 16, 16'h0003);
        rd_check("R2 reg18", 1, 18, 16'h0001);
        rd_check("R2 reg7", 1, 7, 16'h0000);

        // R4/R5 masked writes.
        do_write(4'b0101, 1, 4, 16'hFFFF);
        rd_check("R4 reg4 all ones", 1, 4, 16'hC51F);
        do_write(4'b0101, 1, 4, 16'h0000);
        rd_check("R5 reg4 zeros", 1, 4, 16'h0500);
        do_write(4'b0101, 1, 16, 16'hFFFF);
        rd_check("R5 reg16 ones", 1, 16, 16'h0FFF);
        do_write(4'b0101, 1, 0, 16'h1234);
        rd_check("R5 reg0 readonly", 1, 0, 16'h3100);

        // R8 write then read back-to-back, no preamble.
        do_write(4'b0101, 1, 3, 16'h2AA5);
        rd_check("R8 reg3 back-to-back", 1, 3, 16'h2AA5);

        // R6 foreign PHY address.
        rd_check("R6 read phy2", 2, 1, 16'h0000);
        do_write(4'b0101, 3, 1, 16'h0000);
        rd_check("R6 write phy3 ignored", 1, 1, 16'hF02C);

        // R9 non-write opcode.
        do_write(4'b0100, 1, 3, 16'h1111);
        rd_check("R9 bad opcode", 1, 3, 16'h2AA5);

        // R7 stray bits then preamble.
        send_bits(32'b10010, 5, 0);
        preamble();
        rd_check("R7 after preamble", 1, 5, 16'h4181);

        // R1 long MDC high holds and noise while MDC low.
        do_write(4'b0101, 1, 20, 16'hBEEF, 4);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); mdc = 0; mdo = i[0]; dir = i[1];
            cmp();
        end
        rd_check("R1 hold and noise", 1, 20, 16'hBEEF);

        // R10 MDI holds during write direction.
        mdi_before = mdi;
        do_write(4'b0101, 1, 21, 16'h0F0F);
        check("R10 mdi held in write", int'(mdi), int'(mdi_before));
        rd_check("R4 reg21", 1, 21, 16'h0F0F);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule